// File: doc/BRIEF.md
# I2C byte shift unit

A one-byte serial shift stage for a two-wire bus controller. The host loads or reads one data byte through a simple register strobe interface. The unit then moves that byte across the SDA line one bit per serial clock period, most significant bit first, with a 3-bit counter tracking the bit position. Received bits are taken in at bit 0, so the same register holds outgoing and incoming data. After eight bits the unit raises a one-cycle completion pulse.

Bit timing comes from two synchronous strobes, which run on the single system clock. A rise strobe samples SDA. A fall strobe shifts the register and advances the counter. A host write is accepted only while the enable input is high. An accepted write also clears the counter. If the master input is high at that point, the write requests serial clock generation until the byte completes. After the master input drops, a guard window of GUARD_CYC cycles rejects writes and flags each rejected one. Start/stop, acknowledge, arbitration and interrupts belong to other blocks.

Top module: `i2c_byte_shift`

## Requirements
- R1: After reset: rdata_o is 0x00, sda_o is 1, scl_gen_o, byte_done_o and early_wr_o are 0; the data register resets to 0x00.
- R2: A write (wr_en_i=1) with enable_i=1 and no active guard loads wdata_i into the register and clears the bit counter at the next clock edge.
- R3: A write with enable_i=0 is ignored: register contents and scl_gen_o stay unchanged; while enable_i=0 no shifting occurs.
- R4: From the edge that accepts a write until the byte completes, sda_o carries register bit 7; each fall strobe (scl_fall_i) shifts the register left one place, so the byte leaves MSB first.
- R5: A rise strobe (scl_rise_i) captures sda_i; the next fall strobe shifts that bit into bit 0, so after eight rise/fall pairs the register holds the eight bits in arrival order, first bit in bit 7.
- R6: byte_done_o is high for exactly one cycle, in the cycle after the edge of the eighth fall strobe since the last accepted write.
- R7: When byte_done_o is high, sda_o is released to 1 and scl_gen_o is 0; before any write sda_o is 1.
- R8: An accepted write sets scl_gen_o to 1 when master_i=1 and to 0 when master_i=0.
- R9: If master_i goes from 1 to 0 in cycle t, writes in cycles t to t+GUARD_CYC-1 (default 8) are ignored and each raises early_wr_o for one cycle after its edge; a write in cycle t+GUARD_CYC is accepted.
- R10: A read strobe (rd_en_i=1) copies the register to rdata_o at the next edge whatever enable_i is; rdata_o holds otherwise.
- R11: An accepted write in the middle of a byte restarts the count, so byte_done_o follows only after eight further fall strobes.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wdata_i | input | 8 | Host write data |
| rd_en_i | input | 1 | Host read strobe |
| rdata_o | output | 8 | Host read data |
| enable_i | input | 1 | Unit enable; gates writes and shifting |
| master_i | input | 1 | Master mode select |
| scl_rise_i | input | 1 | SDA sample strobe, one cycle |
| scl_fall_i | input | 1 | Shift strobe, one cycle |
| sda_i | input | 1 | Serial data in |
| sda_o | output | 1 | Serial data drive, 1 is released |
| scl_gen_o | output | 1 | Serial clock generation request |
| byte_done_o | output | 1 | Eighth bit shifted, one-cycle pulse |
| early_wr_o | output | 1 | Write rejected by slave guard, one-cycle pulse |

## Verification
The assertions assume that the rise and fall strobes are single-cycle pulses that never occur together. They also assume that every rise is followed by a fall before the next rise, since the sample register holds only the most recent bit. The bench drives each bit as a rise cycle, an idle cycle and a fall cycle, each cycle separate from the next. It changes master_i only while idle and then waits past the guard window before writing again, except in the directed guard cases. Random bytes, random received bits and random master selection cover transmit and receive together. Directed cases cover writes while disabled, a restart in the middle of a byte, and writes at both edges of the guard window.

// File: rtl/i2c_shift_pkg.sv
package i2c_shift_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/slave_guard.sv
module slave_guard #(
  parameter int unsigned GUARD_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  output logic busy_o
);
  localparam int unsigned GW = (GUARD_CYC > 2) ? $clog2(GUARD_CYC) : 1;

  logic          mst_q;
  logic [GW-1:0] cnt_q;
  logic          fell;

  assign fell   = mst_q & ~master_i;
  assign busy_o = fell | (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mst_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      mst_q <= master_i;
      if (fell)              cnt_q <= GW'(GUARD_CYC - 1);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  // R9
  guard_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !fell) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/bit_shifter.sv
module bit_shifter
  import i2c_shift_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              en_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sda_i,
  output logic [DATA_W-1:0] shreg_o,
  output logic              wrap_o,
  output logic              done_o
);
  localparam int unsigned CW = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic [CW-1:0] cnt_q;
  logic          samp_q;
  logic          step;

  assign step   = en_i & fall_i & ~load_i;
  assign wrap_o = step & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) samp_q <= 1'b1;
    else if (en_i & rise_i) samp_q <= sda_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_o <= '0;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= wrap_o;
      if (load_i) begin
        shreg_o <= data_i;
        cnt_q   <= '0;
      end else if (step) begin
        shreg_o <= {shreg_o[DATA_W-2:0], samp_q};
        cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
    end
  end

  // R2
  load_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == '0 && shreg_o == $past(data_i)));
  // R6
  done_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cnt_q == '0));
  // R3
  no_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(shreg_o));
endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift
  import i2c_shift_pkg::*;
#(
  parameter int unsigned DATA_W    = BYTE_W,
  parameter int unsigned GUARD_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              enable_i,
  input  logic              master_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              scl_gen_o,
  output logic              byte_done_o,
  output logic              early_wr_o
);
  logic              guard_busy;
  logic              wr_ok;
  logic              wr_blk;
  logic              wrap;
  logic              tx_q;
  logic [DATA_W-1:0] shreg;

  assign wr_ok  = wr_en_i & enable_i & ~guard_busy;
  assign wr_blk = wr_en_i & enable_i &  guard_busy;

  slave_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .master_i(master_i),
    .busy_o  (guard_busy)
  );

  bit_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wr_ok),
    .data_i (wdata_i),
    .en_i   (enable_i),
    .rise_i (scl_rise_i),
    .fall_i (scl_fall_i),
    .sda_i  (sda_i),
    .shreg_o(shreg),
    .wrap_o (wrap),
    .done_o (byte_done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q       <= 1'b0;
      scl_gen_o  <= 1'b0;
      early_wr_o <= 1'b0;
      rdata_o    <= '0;
    end else begin
      early_wr_o <= wr_blk;
      if (rd_en_i) rdata_o <= shreg;
      if (wr_ok) begin
        tx_q      <= 1'b1;
        scl_gen_o <= master_i;
      end else if (wrap) begin
        tx_q      <= 1'b0;
        scl_gen_o <= 1'b0;
      end
    end
  end

  // released line unless a byte is in flight
  assign sda_o = tx_q ? shreg[DATA_W-1] : 1'b1;

  // R8
  gen_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_gen_o) |-> $past(master_i && wr_en_i && enable_i));
  // R7
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |-> (sda_o && !scl_gen_o));
  // R9
  early_noload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (early_wr_o && !$past(scl_fall_i) && !$past(wr_ok)) |-> $stable(shreg));
endmodule

// File: tb/i2c_byte_shift_tb.sv
module i2c_byte_shift_tb;
  localparam int CLK_P = 10;

  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, rd_en = 0, en = 0, mst = 0;
  logic       rise = 0, fall = 0, sda_in = 1;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       sda_out, scl_gen, done, early;
  int         n_chk = 0, n_bad = 0;

  i2c_byte_shift u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wdata_i(wdata),
    .rd_en_i(rd_en), .rdata_o(rdata), .enable_i(en), .master_i(mst),
    .scl_rise_i(rise), .scl_fall_i(fall), .sda_i(sda_in), .sda_o(sda_out),
    .scl_gen_o(scl_gen), .byte_done_o(done), .early_wr_o(early)
  );

  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P*150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  function automatic logic [7:0] shift_in(logic [7:0] v, logic b);
    return {v[6:0], b};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic host_write(logic [7:0] b);
    @(negedge clk); wr_en = 1; wdata = b;
    cyc();
    @(negedge clk); wr_en = 0;
  endtask

  task automatic host_read(output logic [7:0] v);
    @(negedge clk); rd_en = 1;
    cyc(); v = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  // one bit: rise with data, idle, fall; samples outputs after fall edge
  task automatic serial_bit(logic b);
    @(negedge clk); rise = 1; sda_in = b;
    @(negedge clk); rise = 0;
    @(negedge clk); fall = 1;
    cyc();
    @(negedge clk); fall = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v, tx, rx_exp;
    void'($urandom(32'd19));
    idle(2);
    #1;
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 sda", sda_out, 1);
    chk("R1 gen/done/early", {scl_gen, done, early}, 3'b000);
    @(negedge clk); rst_n = 1;
    host_read(v);
    chk("R1 reg", v, 8'h00);

    // R3 write ignored while disabled
    host_write(8'h5A);
    host_read(v);
    chk("R3 write ignored", v, 8'h00);
    chk("R3 no gen", scl_gen, 0);
    en = 1;
    host_write(8'hC3);
    host_read(v);
    chk("R2 write loads", v, 8'hC3);
    chk("R8 slave no gen", scl_gen, 0);
    en = 0;
    serial_bit(1'b0);
    host_read(v);
    chk("R3 no shift disabled", v, 8'hC3);
    chk("R10 read while disabled", v, 8'hC3);
    en = 1;

    // random transmit/receive bytes
    for (int it = 0; it < 16; it++) begin
      mst = (it == 0) ? 1'b1 : 1'($urandom);
      idle(GUARD_WAIT);
      tx = (it == 0) ? 8'hB2 : 8'($urandom);
      rx_exp = 0;
      host_write(tx);
      chk("R8 gen follows master", scl_gen, mst);
      for (int b = 7; b >= 0; b--) begin
        logic r;
        r = 1'($urandom);
        #1;
        chk("R4 msb first", sda_out, tx[b]);
        serial_bit(r);
        rx_exp = shift_in(rx_exp, r);
        if (b != 0) chk("R6 no early done", done, 0);
      end
      #1;
      // serial_bit returned one negedge after the done edge
      chk("R7 released", {sda_out, scl_gen}, 2'b10);
      host_read(v);
      chk("R5 rx assembled", v, rx_exp);
      chk("R10 rdata holds", rdata, rx_exp);
    end

    // R6 done pulse timing, R11 restart mid byte
    mst = 0; idle(GUARD_WAIT);
    host_write(8'hF0);
    repeat (3) serial_bit(1'b1);
    host_write(8'h0F);
    for (int b = 0; b < 8; b++) begin
      @(negedge clk); rise = 1; sda_in = 1'b0;
      @(negedge clk); rise = 0;
      @(negedge clk); fall = 1;
      cyc();
      chk(b == 7 ? "R6 done on eighth" : "R11 count restarted", done, b == 7);
      @(negedge clk); fall = 0;
      cyc();
      chk("R6 single pulse", done, 0);
    end

    // R9 guard window
    host_write(8'hA5);
    mst = 1; idle(3);
    @(negedge clk); mst = 0;
    idle(3);
    wr_en = 1; wdata = 8'h11;
    cyc();
    chk("R9 early flagged", early, 1);
    @(negedge clk); wr_en = 0;
    cyc();
    chk("R9 early one cycle", early, 0);
    host_read(v);
    chk("R9 early write ignored", v, 8'hA5);

    mst = 1; idle(3);
    @(negedge clk); mst = 0;
    wr_en = 1; wdata = 8'h22;
    cyc();
    chk("R9 same-cycle blocked", early, 1);
    @(negedge clk); wr_en = 0;
    host_read(v);
    chk("R9 same-cycle ignored", v, 8'hA5);

    mst = 1; idle(3);
    @(negedge clk); mst = 0;
    idle(7);
    wr_en = 1; wdata = 8'h33;
    cyc();
    chk("R9 last guarded cycle", early, 1);
    @(negedge clk); wr_en = 0;

    mst = 1; idle(3);
    @(negedge clk); mst = 0;
    idle(8);
    wr_en = 1; wdata = 8'h44;
    cyc();
    chk("R9 boundary not flagged", early, 0);
    @(negedge clk); wr_en = 0;
    host_read(v);
    chk("R9 boundary accepted", v, 8'h44);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  localparam int GUARD_WAIT = 12;
endmodule